// File: doc/BRIEF.md
# Channel-Change Settling Qualifier

This block sits beside a delta-sigma converter's decimation filter and decides when the filter state must be thrown away and which results coming out of it can be trusted. It keeps a table of eight setup entries, each naming one of four physical input channels. A conversion command carries a 3-bit pointer that selects a setup, and the block resolves the channel to convert from the selected entry.

When a command selects a physical channel different from the one used by the previous command, the block pulses a filter flush. It does not pulse when a different setup index happens to name the same channel, so the filter keeps its history across such a switch. In continuous mode, the first few results after a channel change, a calibration or a single conversion are marked invalid. The number marked invalid depends on whether the output rate is high. Single-mode results are always marked valid.

Top module: `settle_qual`

## Requirements
- R1: After reset, `conv_chan` is 0, `filt_flush` is 0 and `result_valid` is 0. Every setup entry names channel code 0 until it is written. Channel code c (0 to 3) means physical channel c+1.
- R2: A write with `wr_en` high stores `wr_chan` into entry `wr_idx`. A command in cycle t with pointer p sets `conv_chan` to the code stored in entry p, seen after the next clock edge. `conv_chan` changes only on a command.
- R3: `filt_flush` is high for exactly the one cycle after a command, and only when that command's channel differs from the channel of the previous command. It is also high after the first command following reset.
- R4: A command whose setup index differs from the previous command's, but whose channel code is the same, produces no flush.
- R5: A continuous command (`cmd_cont`=1) that flushes, with `rate_high`=0, marks the next 3 conversion results invalid and the 4th and later results valid.
- R6: With `rate_high`=1 sampled at the command, the discard count is 5 instead of 3.
- R7: A `cal_done` pulse, or any single-mode command, causes the next continuous command to discard 3 or 5 results, even when the channel is unchanged and no flush occurs.
- R8: A continuous command on the same channel, with no intervening calibration or single-mode command, marks every result valid from the first one.
- R9: In single mode (`cmd_cont`=0), every `conv_done` sets `result_valid` high.
- R10: `result_valid` goes low in the cycle after any command. Apart from that, it changes only in the cycle after a `conv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Setup entry write strobe |
| wr_idx | input | 3 | Setup entry index to write |
| wr_chan | input | 2 | Channel code to store |
| cmd_valid | input | 1 | Conversion command strobe |
| cmd_ptr | input | 3 | Setup pointer of the command |
| cmd_cont | input | 1 | 1 = continuous, 0 = single |
| rate_high | input | 1 | Output rate at or above the high threshold |
| cal_done | input | 1 | Calibration finished pulse |
| conv_done | input | 1 | Filter produced a result |
| conv_chan | output | 2 | Channel code to convert |
| filt_flush | output | 1 | One-cycle filter reset pulse |
| result_valid | output | 1 | Latest result is settled |

## Verification
The stimulus walks the table through a channel ordering in which setups 2 and 3 share a channel and setups 1, 5, 7 and 8 share another. This separates flushes driven by a change of channel from changes of setup index alone. Continuous runs are started in several situations: after a single command, after a plain same-channel switch, after a channel change at the high rate, and after a calibration. The valid edge therefore has to land on result 1, 4 or 6 depending on the history. A final single command on a new channel checks that the flush still fires and that single results are never discarded.

// File: rtl/settle_qual.sv
module settle_qual #(
  parameter int NSETUP  = 8,
  parameter int CHW     = 2,
  parameter int LOW_DISC  = 3,
  parameter int HIGH_DISC = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(NSETUP)-1:0] wr_idx,
  input  logic [CHW-1:0]            wr_chan,
  input  logic                      cmd_valid,
  input  logic [$clog2(NSETUP)-1:0] cmd_ptr,
  input  logic                      cmd_cont,
  input  logic                      rate_high,
  input  logic                      cal_done,
  input  logic                      conv_done,
  output logic [CHW-1:0]            conv_chan,
  output logic                      filt_flush,
  output logic                      result_valid
);
  localparam int CW = $clog2(HIGH_DISC + 1);

  logic [CHW-1:0] tbl [NSETUP];
  logic           hist, dirty, cont;
  logic [CW-1:0]  cnt;

  wire [CHW-1:0] new_chan = tbl[cmd_ptr];
  wire           chg      = !hist || (new_chan != conv_chan);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSETUP; i++) tbl[i] <= '0;
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_chan;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_chan    <= '0;
      filt_flush   <= 1'b0;
      result_valid <= 1'b0;
      hist         <= 1'b0;
      dirty        <= 1'b0;
      cont         <= 1'b0;
      cnt          <= '0;
    end else begin
      filt_flush <= 1'b0;
      if (cal_done) dirty <= 1'b1;
      if (cmd_valid) begin
        conv_chan    <= new_chan;
        filt_flush   <= chg;
        hist         <= 1'b1;
        cont         <= cmd_cont;
        result_valid <= 1'b0;
        dirty        <= !cmd_cont || cal_done;
        if (cmd_cont && (chg || dirty))
          cnt <= rate_high ? CW'(HIGH_DISC) : CW'(LOW_DISC);
        else
          cnt <= '0;
      end else if (conv_done) begin
        result_valid <= !cont || (cnt == '0);
        if (cont && cnt != '0) cnt <= cnt - 1'b1;
      end
    end
  end

  assert_flush_after_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    filt_flush |-> $past(cmd_valid));
  assert_flush_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    filt_flush && !$past(cmd_valid, 2) |=> !filt_flush || $past(cmd_valid));
  assert_chan_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(conv_chan));
  assert_cmd_clears_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !result_valid);
  assert_valid_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid && !conv_done |=> $stable(result_valid));
  assert_single_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && !cmd_valid && !cont |=> result_valid);
  assert_disc_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(HIGH_DISC));
endmodule

// File: tb/settle_qual_tb.sv
module settle_qual_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, cmd_valid = 0, cmd_cont = 0, rate_high = 0, cal_done = 0, conv_done = 0;
  logic [2:0] wr_idx = 0, cmd_ptr = 0;
  logic [1:0] wr_chan = 0;
  logic [1:0] conv_chan;
  logic filt_flush, result_valid;

  int checks = 0, failures = 0;

  settle_qual u_dut (.clk, .rst_n, .wr_en, .wr_idx, .wr_chan, .cmd_valid, .cmd_ptr,
    .cmd_cont, .rate_high, .cal_done, .conv_done, .conv_chan, .filt_flush, .result_valid);

  always #(CLK_PERIOD/2) clk = ~clk;

  int m_map[8];
  int m_chan = 0, m_disc = 0;
  bit m_flush = 0, m_valid = 0, m_seen = 0, m_stale = 0, m_run = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_map[i]) m_map[i] = 0;
      m_chan = 0; m_flush = 0; m_valid = 0; m_seen = 0; m_stale = 0; m_run = 0; m_disc = 0;
    end else begin
      int c;
      bit pend_cal;
      c = m_map[cmd_ptr];
      pend_cal = m_stale || cal_done;
      m_flush = 0;
      if (cmd_valid) begin
        m_flush = !m_seen || c != m_chan;
        m_disc = (cmd_cont && (m_flush || m_stale)) ? (rate_high ? 5 : 3) : 0;
        m_seen = 1; m_chan = c; m_run = cmd_cont; m_valid = 0;
        m_stale = !cmd_cont || cal_done;
      end else begin
        m_stale = pend_cal;
        if (conv_done) begin
          if (m_run && m_disc > 0) begin m_valid = 0; m_disc--; end
          else m_valid = 1;
        end
      end
      if (wr_en) m_map[wr_idx] = wr_chan;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R2 conv_chan", conv_chan, m_chan);
    check("R3 filt_flush", filt_flush, m_flush);
    check("R5 result_valid", result_valid, m_valid);
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(int i, int c);
    wr_en = 1; wr_idx = 3'(i); wr_chan = 2'(c); tick(); wr_en = 0;
  endtask

  task automatic cmd(int p, bit cont, bit hi, string tag, int exp_chan, bit exp_flush);
    cmd_valid = 1; cmd_ptr = 3'(p); cmd_cont = cont; rate_high = hi; tick();
    cmd_valid = 0;
    check({tag, " chan"}, conv_chan, exp_chan);
    check({tag, " flush"}, filt_flush, exp_flush);
    check("R10 valid cleared", result_valid, 0);
    tick();
    check("R3 flush one cycle", filt_flush, 0);
  endtask

  task automatic results(int n, int first_valid, string tag);
    for (int k = 1; k <= n; k++) begin
      conv_done = 1; tick(); conv_done = 0;
      check(tag, result_valid, k >= first_valid);
      tick();
      check("R10 valid held", result_valid, k >= first_valid);
    end
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    check("R1 chan", conv_chan, 0);
    check("R1 flush", filt_flush, 0);
    check("R1 valid", result_valid, 0);
    cmd(5, 0, 0, "R1 default setup", 0, 1);
    results(2, 1, "R9 single valid");
    wr(0, 3); wr(1, 0); wr(2, 0); wr(3, 1); wr(4, 3); wr(5, 2); wr(6, 3); wr(7, 3);
    cmd(1, 1, 0, "R7 after single", 0, 0);
    results(5, 4, "R7 discard 3");
    cmd(2, 1, 0, "R4 same chan", 0, 0);
    results(3, 1, "R8 no discard");
    cmd(0, 1, 1, "R3 chan change", 3, 1);
    results(7, 6, "R6 discard 5");
    cal_done = 1; tick(); cal_done = 0;
    cmd(4, 1, 0, "R7 after cal", 3, 0);
    results(5, 4, "R7 cal discard");
    cmd(5, 1, 0, "R2 setup6", 2, 1);
    results(5, 4, "R5 discard 3");
    cmd(3, 0, 0, "R2 setup4", 1, 1);
    results(2, 1, "R9 single valid");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule